// File: doc/BRIEF.md
# Platform-Level Interrupt Controller

This block collects `N_SRC` external interrupt sources and delivers them to `N_CTX` hart contexts. A context is one privilege mode on one hardware thread, so `N_CTX = N_THREAD * N_MODE`. For example, 8 threads with 2 modes each give 16 contexts.

Software sets up the routing through a word-addressed register port:
- each source has its own priority;
- each context has its own enable mask and its own priority threshold.

The controller holds one pending bit per source. For every context it raises a single interrupt line while an eligible source exists.

A context services an interrupt in two steps. It reads its claim register, which returns the ID of the best eligible source and atomically takes that source out of circulation. Once the interrupt is handled, the context writes the same ID back to complete it. A claimed source stays invisible to every context until that completion arrives. Each source is built at elaboration as edge or level sensitive. Software uses the same claim and complete sequence for both kinds.

The register port is valid/ready on both the request and the response side, and it keeps one response outstanding at a time. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Every accepted request, read or write, returns exactly one response on the next cycle. The response stays valid, with constant data, until `rsp_ready` is high at a clock edge. While a response waits unaccepted, `req_ready` is low, so the requester's back-pressure stalls new requests rather than losing them. The interrupt lines and the source inputs are plain level signals.

Top module: `irqc_top`

## Requirements
- R1: After reset, all interrupt lines are low, no source is pending or claimed, and every priority, enable and threshold register reads 0.
- R2: A claim read returns the ID of the eligible source with the highest priority. Lower-priority sources are returned only by later claims.
- R3: When several eligible sources share the highest priority, a claim returns the lowest ID among them.
- R4: Each context has its own enable mask. A source disabled for a context never raises that context's line and is never returned by that context's claim, even while another context sees it.
- R5: A pending enabled source is eligible for a context only if its priority is greater than or equal to that context's threshold. The threshold resets to 0.
- R6: A source with priority 0 is never eligible, although its pending bit can be set. ID 0 is reserved for "no interrupt", and its priority register reads 0.
- R7: An accepted claim read clears the chosen source's pending bit and marks the source claimed in that same cycle. A claimed source is then hidden from every context. A claim with nothing eligible returns 0 and changes no state.
- R8: An edge source becomes pending on a rising edge of its input. While the source is claimed, any number of further rising edges are remembered as at most one request, which becomes pending when the source is completed.
- R9: A level source becomes pending while its input is high and it is not claimed. If the input is still high after completion, the source becomes pending again.
- R10: A complete write whose data is 0, out of range, or the ID of a source that is not claimed changes no state.
- R11: Each context's line is a register: it changes exactly one clock cycle after the change in pending, enable, priority or threshold state that causes it.
- R12: While a response is valid and `rsp_ready` is low, `req_ready` is low and `rsp_valid` and `rsp_rdata` hold their values. Each accepted request produces exactly one response on the next cycle.
- R13: Register word map (8-bit word address). Addresses not listed read 0 and ignore writes.
  - `0x01..N_SRC`: priority of the source whose ID equals the address.
  - `0x40`: read-only pending bitmap; bit i is source i.
  - `0x80 + c`: enable mask of context c; bit i is source i, and bit 0 is ignored.
  - `0xC0 + 2c`: threshold of context c.
  - `0xC1 + 2c`: claim (on read) and complete (on write) for context c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | N_SRC | Interrupt inputs; bit i (index range N_SRC..1) is source ID i |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Word address of the register |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | DATA_W | Read data; 0 for write responses |
| ctx_irq | output | N_CTX | Interrupt request line of each context |

## Verification
Wrong internal state in this block becomes visible at the ports within one or two cycles.
- A lost or duplicated pending bit shows up in the pending bitmap on the next read, and as a wrong ID on the next claim.
- A claimed flag that is stuck or released early shows as a source that never re-pends after completion, or one that re-pends while it is still claimed.
- A bad eligibility term, whether enable, priority or threshold, appears on `ctx_irq` exactly one cycle after the register write. It also appears as a wrong claim result.

The directed scenarios probe each of these through reads and line samples taken at the cycle where the registered outputs must have changed.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 6;
  localparam int CTX_IW = 5;

  typedef enum logic [1:0] {
    RG_PRIO = 2'd0,
    RG_PEND = 2'd1,
    RG_EN   = 2'd2,
    RG_CTX  = 2'd3
  } irqc_region_e;
endpackage

// File: rtl/irqc_gateway.sv
module irqc_gateway #(
  parameter bit EDGE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  input  logic claim,
  input  logic done,
  output logic pending,
  output logic busy
);
  logic prev_q, held_q, req;

  // edge sources request on a rising edge, level sources while high
  generate
    if (EDGE) begin : g_edge
      assign req = irq_in & ~prev_q;
    end else begin : g_level
      assign req = irq_in;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      pending <= 1'b0;
      busy    <= 1'b0;
      held_q  <= 1'b0;
    end else begin
      prev_q <= irq_in;
      if (claim) begin
        pending <= 1'b0;
        busy    <= 1'b1;
        held_q  <= EDGE & req;
      end else if (done) begin
        busy    <= 1'b0;
        pending <= EDGE & (held_q | req);
        held_q  <= 1'b0;
      end else if (req) begin
        if (busy) held_q <= EDGE;
        else      pending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
  parameter int N_SRC  = 15,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC:0]             pend,
  input  logic [N_SRC:0]             en,
  input  logic [N_SRC:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]          thr,
  output logic [ID_W-1:0]            best_id,
  output logic                       any
);
  logic [N_SRC:0] elig;
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    for (int i = 0; i <= N_SRC; i++)
      elig[i] = pend[i] & en[i] & (prio[i] != '0) & (prio[i] >= thr);
  end

  // strict compare while scanning upward keeps the lowest ID on ties
  always_comb begin
    best_id = '0;
    best_p  = '0;
    for (int i = 0; i <= N_SRC; i++) begin
      if (elig[i] && prio[i] > best_p) begin
        best_id = ID_W'(i);
        best_p  = prio[i];
      end
    end
  end

  assign any = |elig;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int          N_SRC    = 15,
  parameter int          PRIO_W   = 3,
  parameter int          N_THREAD = 2,
  parameter int          N_MODE   = 2,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] SRC_EDGE = 32'h0000_00FE,
  localparam int         N_CTX    = N_THREAD * N_MODE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SRC:1]       src_irq,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [N_CTX-1:0]     ctx_irq
);
  localparam int ID_W = $clog2(N_SRC + 1);

  logic [N_SRC:0][PRIO_W-1:0] prio_q;
  logic [N_SRC:0]             en_q [N_CTX];
  logic [PRIO_W-1:0]          thr_q [N_CTX];
  logic [N_SRC:0]             pend_vec, busy_vec, claim_vec, done_vec;
  logic [ID_W-1:0]            best_id [N_CTX];
  logic [N_CTX-1:0]           any_w;

  logic                 acc, claim_hit, done_hit, ctx_ok;
  irqc_region_e         region;
  logic [IDX_W-1:0]     idx;
  logic [CTX_IW-1:0]    ctx_idx;
  logic [ID_W-1:0]      sel_id;
  logic [DATA_W-1:0]    rd_d;

  // request / response handshake: one response outstanding
  assign req_ready = ~rsp_valid | rsp_ready;
  assign acc       = req_valid & req_ready;
  assign region    = irqc_region_e'(req_addr[7:6]);
  assign idx       = req_addr[5:0];
  assign ctx_idx   = req_addr[5:1];
  assign ctx_ok    = int'(ctx_idx) < N_CTX;
  assign claim_hit = acc & ~req_write & (region == RG_CTX) & req_addr[0] & ctx_ok;
  assign done_hit  = acc &  req_write & (region == RG_CTX) & req_addr[0] & ctx_ok;

  // gateways, one per source
  assign pend_vec[0]  = 1'b0;
  assign busy_vec[0]  = 1'b0;
  assign claim_vec[0] = 1'b0;
  assign done_vec[0]  = 1'b0;
  generate
    for (genvar i = 1; i <= N_SRC; i++) begin : g_src
      assign claim_vec[i] = claim_hit && (sel_id == ID_W'(i));
      assign done_vec[i]  = done_hit && (req_wdata == DATA_W'(i)) && busy_vec[i];
      irqc_gateway #(.EDGE(SRC_EDGE[i])) u_gw (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (src_irq[i]),
        .claim   (claim_vec[i]),
        .done    (done_vec[i]),
        .pending (pend_vec[i]),
        .busy    (busy_vec[i])
      );
    end
  endgenerate

  // arbitration, one per context
  generate
    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
      irqc_select #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_sel (
        .pend    (pend_vec),
        .en      (en_q[c]),
        .prio    (prio_q),
        .thr     (thr_q[c]),
        .best_id (best_id[c]),
        .any     (any_w[c])
      );
    end
  endgenerate

  always_comb begin
    sel_id = '0;
    for (int c = 0; c < N_CTX; c++)
      if (ctx_idx == CTX_IW'(c)) sel_id = best_id[c];
  end

  // read data
  always_comb begin
    rd_d = '0;
    if (!req_write) begin
      case (region)
        RG_PRIO: for (int i = 1; i <= N_SRC; i++)
                   if (idx == IDX_W'(i)) rd_d = DATA_W'(prio_q[i]);
        RG_PEND: if (idx == '0) rd_d = DATA_W'(pend_vec);
        RG_EN:   for (int c = 0; c < N_CTX; c++)
                   if (idx == IDX_W'(c)) rd_d = DATA_W'(en_q[c]);
        RG_CTX:  for (int c = 0; c < N_CTX; c++)
                   if (ctx_idx == CTX_IW'(c))
                     rd_d = req_addr[0] ? DATA_W'(best_id[c]) : DATA_W'(thr_q[c]);
        default: rd_d = '0;
      endcase
    end
  end

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      for (int c = 0; c < N_CTX; c++) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end
    end else if (acc && req_write) begin
      case (region)
        RG_PRIO: for (int i = 1; i <= N_SRC; i++)
                   if (idx == IDX_W'(i)) prio_q[i] <= req_wdata[PRIO_W-1:0];
        RG_EN:   for (int c = 0; c < N_CTX; c++)
                   if (idx == IDX_W'(c)) en_q[c] <= {req_wdata[N_SRC:1], 1'b0};
        RG_CTX:  for (int c = 0; c < N_CTX; c++)
                   if (ctx_idx == CTX_IW'(c) && !req_addr[0])
                     thr_q[c] <= req_wdata[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  // response and interrupt lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      ctx_irq   <= '0;
    end else begin
      ctx_irq <= any_w;
      if (acc) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_d;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{req_wdata, req_wdata[0]};
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int N_SRC  = 15,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_ready,
  input logic                       rsp_valid,
  input logic                       rsp_ready,
  input logic [DATA_W-1:0]          rsp_rdata,
  input logic [N_SRC:0]             pend_vec,
  input logic [N_SRC:0]             busy_vec,
  input logic [N_SRC:0]             claim_vec,
  input logic [N_SRC:0]             done_vec,
  input logic [N_SRC:0][PRIO_W-1:0] prio_q
);
  assert_resp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  assert_blocked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  assert_one_claim_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_vec));

  generate
    for (genvar i = 1; i <= N_SRC; i++) begin : g_src
      assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_vec[i] && busy_vec[i]));
      assert_claim_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_vec[i]) |-> $past(claim_vec[i]));
      assert_done_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_vec[i]) |-> $past(done_vec[i]));
      assert_prio_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        claim_vec[i] |-> prio_q[i] != '0);
      assert_claim_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        claim_vec[i] |-> pend_vec[i] ##1 !pend_vec[i] && busy_vec[i]);
    end
  endgenerate
endmodule

bind irqc_top irqc_chk #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .pend_vec  (pend_vec),
  .busy_vec  (busy_vec),
  .claim_vec (claim_vec),
  .done_vec  (done_vec),
  .prio_q    (prio_q)
);

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;
  localparam int N_SRC = 15;
  localparam int N_CTX = 4;
  localparam logic [7:0] A_PEND = 8'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_SRC:1] src_irq = '0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [N_CTX-1:0] ctx_irq;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irqc_top dut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .ctx_irq(ctx_irq)
  );

  function automatic logic [7:0] a_en(int c);  return 8'(8'h80 + c);     endfunction
  function automatic logic [7:0] a_thr(int c); return 8'(8'hC0 + 2 * c); endfunction
  function automatic logic [7:0] a_clm(int c); return 8'(8'hC1 + 2 * c); endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    q = rsp_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] q;
    xfer(1'b1, a, d, q);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] q);
    xfer(1'b0, a, 32'h0, q);
  endtask

  task automatic pulse(input int id);
    @(negedge clk); src_irq[id] = 1'b1;
    @(negedge clk); src_irq[id] = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] q;
    check("R1 lines after reset", 32'(ctx_irq), 32'h0);
    rd(A_PEND, q);   check("R1 pending after reset", q, 32'h0);
    rd(a_thr(0), q); check("R1 threshold after reset", q, 32'h0);
    rd(8'h05, q);    check("R1 priority after reset", q, 32'h0);
    rd(8'h00, q);    check("R6 ID 0 priority", q, 32'h0);
    rd(a_clm(0), q); check("R7 empty claim", q, 32'h0);
  endtask

  task automatic t_prio;
    logic [31:0] q;
    wr(8'h03, 2); wr(8'h05, 6); wr(a_en(0), 32'h28);
    pulse(3); pulse(5); idle(2);
    check("R2 line raised", 32'(ctx_irq[0]), 32'h1);
    rd(a_clm(0), q); check("R2 first claim highest", q, 5);
    rd(a_clm(0), q); check("R2 second claim", q, 3);
    rd(a_clm(0), q); check("R7 claim after drain", q, 0);
    idle(1);
    check("R11 line low after claims", 32'(ctx_irq[0]), 32'h0);
    wr(a_clm(0), 5); wr(a_clm(0), 3);
  endtask

  task automatic t_tie;
    logic [31:0] q;
    wr(8'h02, 4); wr(8'h04, 4); wr(a_en(0), 32'h14);
    pulse(4); pulse(2); idle(2);
    rd(a_clm(0), q); check("R3 tie lowest ID", q, 2);
    rd(a_clm(0), q); check("R3 tie second", q, 4);
    wr(a_clm(0), 2); wr(a_clm(0), 4);
  endtask

  task automatic t_enable;
    logic [31:0] q;
    wr(8'h06, 1); wr(a_en(0), 0); wr(a_en(1), 32'h40);
    pulse(6); idle(2);
    check("R4 only ctx1 line", 32'(ctx_irq), 32'h2);
    rd(a_clm(0), q); check("R4 disabled ctx claim", q, 0);
    rd(a_clm(1), q); check("R4 enabled ctx claim", q, 6);
    wr(a_clm(1), 6);
    // shared source hidden from other contexts once claimed
    wr(a_en(0), 32'h40);
    pulse(6); idle(2);
    check("R4 both lines", 32'(ctx_irq[1:0]), 32'h3);
    rd(a_clm(1), q); check("R7 claim shared", q, 6);
    rd(A_PEND, q);   check("R7 pending cleared", q & 32'h40, 0);
    rd(a_clm(0), q); check("R7 hidden from ctx0", q, 0);
    check("R7 ctx0 line dropped", 32'(ctx_irq[0]), 32'h0);
    wr(a_clm(0), 6);
    wr(a_en(1), 0);
  endtask

  task automatic t_thresh;
    logic [31:0] q;
    wr(8'h06, 3); wr(a_thr(0), 4);
    pulse(6); idle(2);
    check("R5 below threshold line", 32'(ctx_irq[0]), 32'h0);
    rd(a_clm(0), q); check("R5 below threshold claim", q, 0);
    wr(a_thr(0), 3);
    check("R11 line not yet updated", 32'(ctx_irq[0]), 32'h0);
    @(negedge clk);
    check("R5 equal threshold line", 32'(ctx_irq[0]), 32'h1);
    rd(a_clm(0), q); check("R5 equal threshold claim", q, 6);
    wr(a_clm(0), 6); wr(a_thr(0), 0);
  endtask

  task automatic t_prio0;
    logic [31:0] q;
    wr(a_en(0), 32'h80);
    pulse(7); idle(2);
    check("R6 prio 0 line", 32'(ctx_irq[0]), 32'h0);
    rd(A_PEND, q);   check("R6 prio 0 still pending", q & 32'h80, 32'h80);
    rd(a_clm(0), q); check("R6 prio 0 claim", q, 0);
    wr(8'h07, 1); idle(1);
    rd(a_clm(0), q); check("R6 after prio set", q, 7);
    wr(a_clm(0), 7);
  endtask

  task automatic t_edge;
    logic [31:0] q;
    wr(a_en(0), 32'h08);
    pulse(3); idle(1);
    rd(a_clm(0), q); check("R8 edge claim", q, 3);
    pulse(3); pulse(3); idle(1);
    rd(A_PEND, q);   check("R8 not pending while claimed", q & 32'h08, 0);
    rd(a_clm(0), q); check("R8 no claim while claimed", q, 0);
    wr(a_clm(0), 3); idle(1);
    rd(A_PEND, q);   check("R8 held edge pending", q & 32'h08, 32'h08);
    rd(a_clm(0), q); check("R8 held edge claim", q, 3);
    wr(a_clm(0), 3); idle(1);
    rd(a_clm(0), q); check("R8 only one held", q, 0);
  endtask

  task automatic t_level;
    logic [31:0] q;
    wr(8'h09, 2); wr(a_en(0), 32'h200);
    @(negedge clk); src_irq[9] = 1'b1; idle(2);
    rd(a_clm(0), q); check("R9 level claim", q, 9);
    idle(2);
    rd(A_PEND, q);   check("R9 not pending while claimed", q & 32'h200, 0);
    wr(a_clm(0), 8); idle(2);
    rd(A_PEND, q);   check("R10 wrong ID ignored", q & 32'h200, 0);
    wr(a_clm(0), 0); idle(2);
    rd(a_clm(0), q); check("R10 ID 0 ignored", q, 0);
    wr(a_clm(0), 9); idle(2);
    rd(A_PEND, q);   check("R9 re-pend while high", q & 32'h200, 32'h200);
    rd(a_clm(0), q); check("R9 reclaim", q, 9);
    @(negedge clk); src_irq[9] = 1'b0;
    wr(a_clm(0), 9); idle(2);
    rd(A_PEND, q);   check("R9 no re-pend when low", q & 32'h200, 0);
    check("R9 line low", 32'(ctx_irq[0]), 32'h0);
  endtask

  task automatic t_backpressure;
    logic [31:0] q;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h09;
    @(negedge clk);
    req_valid = 1'b0;
    q = rsp_rdata;
    check("R12 response valid", 32'(rsp_valid), 1);
    check("R13 priority readback", q, 2);
    idle(3);
    check("R12 held valid", 32'(rsp_valid), 1);
    check("R12 held data", rsp_rdata, 2);
    check("R12 request stalled", 32'(req_ready), 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R12 response consumed", 32'(rsp_valid), 0);
    rd(a_en(0), q); check("R13 enable readback", q, 32'h200);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_prio;
    t_tie;
    t_enable;
    t_thresh;
    t_prio0;
    t_edge;
    t_level;
    t_backpressure;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule